// File: doc/BRIEF.md
# Block Register Transfer Sequencer

This block turns one block load or block store request into a run of single-word transfers. A start pulse captures a base address, a 16-bit register selection mask, an addressing order, a load/store flag and a writeback flag. The block then issues one transfer per cycle, one for each selected register, in ascending register index. Each transfer carries the register index and its word address. The memory port and the register file sit outside the block: they react to the valid strobe and pick up the address and index.

Four word orders are supported: increment-after, increment-before, decrement-after and decrement-before. A stack mode can be chosen instead. It combines full or empty pointer semantics with ascending or descending growth, and together with the load/store flag it resolves to one of the four orders. After the last transfer the block raises done for one cycle and presents the new base value. That value has moved by four bytes per selected register when writeback is requested, and equals the original base when it is not.

Top module: `blkxfer_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, `xfer_vld` and `done` are low and `base_out` is zero.
- R2: For every set bit of `reg_list`, exactly one transfer is issued, with `xfer_vld` high. Transfers come in ascending register index and carry that index on `xfer_reg`. Clear bits produce no transfer, and transfers occupy consecutive cycles starting the cycle after the start pulse is sampled.
- R3: Consecutive transfers of one operation have addresses exactly 4 apart, rising. The lowest selected register therefore always gets the lowest address.
- R4: With `stack_en` low, `mode` chooses the order: 0 increment-after (first address = base), 1 increment-before (base+4), 2 decrement-after (base-4N+4), 3 decrement-before (base-4N). N is the number of set bits.
- R5: With `stack_en` high, `mode[1]` is 0 for full and 1 for empty, and `mode[0]` is 0 for descending and 1 for ascending. Stores (`is_load`=0) map full-descending, full-ascending, empty-descending and empty-ascending to decrement-before, increment-before, decrement-after and increment-after respectively. Loads map them to increment-after, decrement-after, increment-before and decrement-before.
- R6: With `wb_en` high, `base_out` at done equals base+4N for increment orders and base-4N for decrement orders (modulo 2^AW).
- R7: With `wb_en` low, `base_out` at done equals the original base.
- R8: `done` is high for exactly one cycle, in the cycle right after the last transfer, and never together with `xfer_vld`. `base_out` stays unchanged while transfers are in progress.
- R9: An empty `reg_list` raises `done` in the cycle right after the start pulse is sampled. It issues no transfer, and `base_out` equals the base whatever `wb_en` is.
- R10: A start pulse that arrives while an operation is in progress (transfer or done cycle) is ignored. The running transfers and the final base are unaffected.
- R11: A full-descending store with writeback, followed by a full-descending load with writeback of the same list from the returned base, uses the same address for every register and returns the original base.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| base_addr | input | AW | Base address |
| reg_list | input | 16 | Register selection mask, bit i selects register i |
| stack_en | input | 1 | 1: interpret `mode` as a stack mode |
| mode | input | 2 | Word order, or stack full/empty and growth direction |
| is_load | input | 1 | 1 load, 0 store (used for stack modes) |
| wb_en | input | 1 | Request base writeback value |
| xfer_vld | output | 1 | A word transfer is presented this cycle |
| xfer_addr | output | AW | Byte address of the current transfer |
| xfer_reg | output | 4 | Register index of the current transfer |
| done | output | 1 | Operation finished (one-cycle pulse) |
| base_out | output | AW | Final base value of the last operation |

## Verification
The checker watches every cycle for properties that hold across any operation. Back-to-back transfers step by exactly four bytes with a strictly increasing register index. Done and the transfer strobe never overlap, done lasts a single cycle, and the returned base holds still during transfers. The checker cannot tell whether the first address, the final base, the stack-name mapping, the empty-list timing or the push/pop round trip are correct. Only the bench's scenarios show those, by comparing each operation's full sequence against values computed from the mode rules.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

    localparam int LIST_W = 16;
    localparam int IDX_W  = $clog2(LIST_W);
    localparam int CNT_W  = $clog2(LIST_W + 1);

    typedef enum logic [1:0] {
        ORD_INC_AFTER  = 2'd0,
        ORD_INC_BEFORE = 2'd1,
        ORD_DEC_AFTER  = 2'd2,
        ORD_DEC_BEFORE = 2'd3
    } order_e;

    typedef struct packed {
        logic       stack_en;
        logic [1:0] mode;
        logic       is_load;
    } mode_req_t;

    function automatic logic [CNT_W-1:0] list_count(input logic [LIST_W-1:0] l);
        logic [CNT_W-1:0] c;
        c = '0;
        for (int i = 0; i < LIST_W; i++) begin
            c = c + CNT_W'(l[i]);
        end
        return c;
    endfunction

    function automatic logic [IDX_W-1:0] lowest_set(input logic [LIST_W-1:0] l);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = LIST_W - 1; i >= 0; i--) begin
            if (l[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

    function automatic logic order_rises(input order_e o);
        return (o == ORD_INC_AFTER) || (o == ORD_INC_BEFORE);
    endfunction

endpackage

// File: rtl/blkxfer_mode_map.sv
module blkxfer_mode_map
    import blkxfer_pkg::*;
(
    input  mode_req_t req,
    output order_e    order
);
    // Stack name = {empty, ascending}; resolved with the load/store flag.
    always_comb begin
        if (!req.stack_en) begin
            order = order_e'(req.mode);
        end else begin
            unique case ({req.mode, req.is_load})
                3'b00_0: order = ORD_DEC_BEFORE; // full desc store
                3'b00_1: order = ORD_INC_AFTER;  // full desc load
                3'b01_0: order = ORD_INC_BEFORE; // full asc store
                3'b01_1: order = ORD_DEC_AFTER;  // full asc load
                3'b10_0: order = ORD_DEC_AFTER;  // empty desc store
                3'b10_1: order = ORD_INC_BEFORE; // empty desc load
                3'b11_0: order = ORD_INC_AFTER;  // empty asc store
                default: order = ORD_DEC_BEFORE; // empty asc load
            endcase
        end
    end
endmodule

// File: rtl/blkxfer_addr_calc.sv
module blkxfer_addr_calc
    import blkxfer_pkg::*;
#(
    parameter int AW         = 32,
    parameter int WORD_BYTES = 4
) (
    input  order_e           order,
    input  logic [AW-1:0]    base,
    input  logic [CNT_W-1:0] count,
    input  logic             wb_en,
    output logic [AW-1:0]    first_addr,
    output logic [AW-1:0]    final_base
);
    localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

    logic [AW-1:0] span;

    always_comb begin
        span = AW'(count) * STEP;
        unique case (order)
            ORD_INC_AFTER:  first_addr = base;
            ORD_INC_BEFORE: first_addr = base + STEP;
            ORD_DEC_AFTER:  first_addr = base - span + STEP;
            default:        first_addr = base - span;
        endcase
        if (!wb_en) begin
            final_base = base;
        end else if (order_rises(order)) begin
            final_base = base + span;
        end else begin
            final_base = base - span;
        end
    end
endmodule

// File: rtl/blkxfer_list_walk.sv
module blkxfer_list_walk
    import blkxfer_pkg::*;
#(
    parameter int AW         = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LIST_W-1:0] list_in,
    input  logic [AW-1:0]     first_addr,
    input  logic [AW-1:0]     final_base,
    output logic              xfer_vld,
    output logic [AW-1:0]     xfer_addr,
    output logic [IDX_W-1:0]  xfer_reg,
    output logic              done,
    output logic [AW-1:0]     base_out
);
    localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

    logic              busy_q;
    logic [LIST_W-1:0] rem_q;
    logic [AW-1:0]     addr_q;
    logic [AW-1:0]     base_q;
    logic [IDX_W-1:0]  cur_idx;
    logic              rem_any;

    always_comb begin
        rem_any = |rem_q;
        cur_idx = lowest_set(rem_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            rem_q  <= '0;
            addr_q <= '0;
            base_q <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                rem_q  <= list_in;
                addr_q <= first_addr;
                base_q <= final_base;
            end
        end else if (!rem_any) begin
            busy_q <= 1'b0;
        end else begin
            rem_q[cur_idx] <= 1'b0;
            addr_q         <= addr_q + STEP;
        end
    end

    assign xfer_vld  = busy_q && rem_any;
    assign done      = busy_q && !rem_any;
    assign xfer_addr = addr_q;
    assign xfer_reg  = cur_idx;
    assign base_out  = base_q;
endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
    import blkxfer_pkg::*;
#(
    parameter int AW         = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] base_addr,
    input  logic [15:0]   reg_list,
    input  logic          stack_en,
    input  logic [1:0]    mode,
    input  logic          is_load,
    input  logic          wb_en,
    output logic          xfer_vld,
    output logic [AW-1:0] xfer_addr,
    output logic [3:0]    xfer_reg,
    output logic          done,
    output logic [AW-1:0] base_out
);
    mode_req_t        req;
    order_e           order;
    logic [CNT_W-1:0] count;
    logic [AW-1:0]    first_addr;
    logic [AW-1:0]    final_base;

    always_comb begin
        req.stack_en = stack_en;
        req.mode     = mode;
        req.is_load  = is_load;
        count        = list_count(reg_list);
    end

    blkxfer_mode_map u_map (
        .req   (req),
        .order (order)
    );

    blkxfer_addr_calc #(.AW(AW), .WORD_BYTES(WORD_BYTES)) u_calc (
        .order      (order),
        .base       (base_addr),
        .count      (count),
        .wb_en      (wb_en),
        .first_addr (first_addr),
        .final_base (final_base)
    );

    blkxfer_list_walk #(.AW(AW), .WORD_BYTES(WORD_BYTES)) u_walk (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .list_in    (reg_list),
        .first_addr (first_addr),
        .final_base (final_base),
        .xfer_vld   (xfer_vld),
        .xfer_addr  (xfer_addr),
        .xfer_reg   (xfer_reg),
        .done       (done),
        .base_out   (base_out)
    );
endmodule

// File: rtl/blkxfer_chk.sv
module blkxfer_chk #(
    parameter int AW         = 32,
    parameter int WORD_BYTES = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          xfer_vld,
    input logic [AW-1:0] xfer_addr,
    input logic [3:0]    xfer_reg,
    input logic          done,
    input logic [AW-1:0] base_out
);
    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_vld && $past(xfer_vld)) |-> (xfer_addr == $past(xfer_addr) + AW'(WORD_BYTES)));

    // R2
    reg_order_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_vld && $past(xfer_vld)) |-> (xfer_reg > $past(xfer_reg)));

    // R8
    done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && xfer_vld));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !xfer_vld));

    // R8
    base_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_vld && $past(xfer_vld)) |-> $stable(base_out));
endmodule

bind blkxfer_seq blkxfer_chk #(.AW(AW), .WORD_BYTES(WORD_BYTES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .xfer_vld  (xfer_vld),
    .xfer_addr (xfer_addr),
    .xfer_reg  (xfer_reg),
    .done      (done),
    .base_out  (base_out)
);

// File: tb/test_blkxfer_seq.sv
`timescale 1ns/1ps
module test_blkxfer_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] base_addr = '0;
    logic [15:0] reg_list = '0;
    logic        stack_en = 1'b0;
    logic [1:0]  mode = '0;
    logic        is_load = 1'b0;
    logic        wb_en = 1'b0;
    logic        xfer_vld;
    logic [31:0] xfer_addr;
    logic [3:0]  xfer_reg;
    logic        done;
    logic [31:0] base_out;

    int errors = 0;
    int checks = 0;
    bit finished = 0;
    logic [31:0] seen_addr [16];

    always #2 clk = ~clk;

    blkxfer_seq i_blkxfer_seq (
        .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
        .reg_list(reg_list), .stack_en(stack_en), .mode(mode),
        .is_load(is_load), .wb_en(wb_en), .xfer_vld(xfer_vld),
        .xfer_addr(xfer_addr), .xfer_reg(xfer_reg), .done(done),
        .base_out(base_out)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // 0 IA, 1 IB, 2 DA, 3 DB
    function automatic int pick_order(bit st, logic [1:0] m, bit ld);
        if (!st) return int'(m);
        case (m)
            2'd0: return ld ? 0 : 3;
            2'd1: return ld ? 2 : 1;
            2'd2: return ld ? 1 : 2;
            default: return ld ? 3 : 0;
        endcase
    endfunction

    function automatic int popc(logic [15:0] l);
        int n = 0;
        for (int i = 0; i < 16; i++) n += int'(l[i]);
        return n;
    endfunction

    task automatic run_op(input bit st, input logic [1:0] m, input bit ld,
                          input bit wb, input logic [31:0] b, input logic [15:0] l,
                          input bit inject, input string tag);
        int n = popc(l);
        int ord = pick_order(st, m, ld);
        logic [31:0] span = 32'(n * 4);
        logic [31:0] first;
        logic [31:0] fin;
        logic [15:0] rem = l;
        case (ord)
            0: first = b;
            1: first = b + 4;
            2: first = b - span + 4;
            default: first = b - span;
        endcase
        fin = !wb ? b : (ord < 2 ? b + span : b - span);
        @(negedge clk);
        stack_en = st; mode = m; is_load = ld; wb_en = wb;
        base_addr = b; reg_list = l; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < n; i++) begin
            int idx = 0;
            for (int j = 15; j >= 0; j--) if (rem[j]) idx = j;
            rem[idx] = 1'b0;
            check(xfer_vld === 1'b1, {tag, " R2 vld"}, 32'(xfer_vld), 1);
            check(xfer_reg === 4'(idx), {tag, " R2 reg"}, 32'(xfer_reg), 32'(idx));
            check(xfer_addr === first + 32'(4 * i), {tag, " R3/R4/R5 addr"},
                  xfer_addr, first + 32'(4 * i));
            seen_addr[idx] = xfer_addr;
            if (inject && i == 0) begin
                // R10: start while busy, other list and base
                base_addr = b ^ 32'h0000_1000; reg_list = ~l; wb_en = ~wb; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check(done === 1'b1 && xfer_vld === 1'b0, {tag, " R8/R9 done"},
              {30'd0, done, xfer_vld}, 32'd2);
        check(base_out === fin, {tag, " R6/R7 base"}, base_out, fin);
        @(negedge clk);
        check(done === 1'b0 && xfer_vld === 1'b0, {tag, " R8 pulse"},
              {30'd0, done, xfer_vld}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1
        check(xfer_vld === 1'b0 && done === 1'b0, "R1 outputs in reset",
              {30'd0, xfer_vld, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(xfer_vld === 1'b0 && done === 1'b0 && base_out === 32'd0,
              "R1 after reset", base_out, 0);

        // R4 plain orders, R6 writeback
        run_op(0, 2'd0, 0, 1, 32'h0000_1000, 16'b0000_0000_0101_1110, 0, "IA");
        run_op(0, 2'd1, 1, 1, 32'h0000_1000, 16'h8001, 0, "IB");
        run_op(0, 2'd2, 0, 1, 32'h0000_2000, 16'h00F0, 0, "DA");
        run_op(0, 2'd3, 1, 1, 32'h0000_2000, 16'hFFFF, 0, "DB");
        // R7 no writeback
        run_op(0, 2'd3, 0, 0, 32'h0000_3000, 16'h0421, 0, "DB nowb");
        // R5 stack aliases
        for (int k = 0; k < 8; k++) begin
            run_op(1, 2'(k >> 1), k[0], 1, 32'h0000_8000, 16'h1234, 0, "R5 stack");
        end
        // R9 empty list
        run_op(0, 2'd1, 0, 1, 32'h0000_4444, 16'h0000, 0, "R9 empty");
        run_op(1, 2'd0, 0, 1, 32'h0000_0004, 16'h0000, 0, "R9 empty stack");
        // R10 start while busy ignored
        run_op(0, 2'd0, 0, 1, 32'h0000_5000, 16'h0F00, 1, "R10");
        // address wrap
        run_op(0, 2'd3, 0, 1, 32'h0000_0008, 16'h0007, 0, "wrap");

        // R11 full-descending push then pop
        begin
            logic [31:0] sp0 = 32'h0001_0000;
            logic [31:0] sp1;
            logic [31:0] push_a [16];
            logic [15:0] lst = 16'b0100_0000_1111_1111;
            run_op(1, 2'd0, 0, 1, sp0, lst, 0, "R11 push");
            sp1 = base_out;
            for (int i = 0; i < 16; i++) push_a[i] = seen_addr[i];
            run_op(1, 2'd0, 1, 1, sp1, lst, 0, "R11 pop");
            for (int i = 0; i < 16; i++) begin
                if (lst[i]) check(seen_addr[i] === push_a[i], "R11 same slot",
                                  seen_addr[i], push_a[i]);
            end
            check(base_out === sp0, "R11 sp restored", base_out, sp0);
        end

        // random operations
        void'($urandom(32'd20240611));
        for (int k = 0; k < 60; k++) begin
            logic [15:0] l = 16'($urandom);
            if (k % 7 == 0) l = 16'(1 << ($urandom % 16));
            run_op(1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
                   $urandom & 32'hFFFF_FFFC, l, (k % 5 == 0), "rand");
        end

        if (!finished) begin
            finished = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule